// File: doc/BRIEF.md
# Receiver Error Flag Controller

This block produces the active-high error flag of a biphase-mark digital audio receiver, together with a mute request for the audio data path. It combines the PLL lock state, per-subframe parity and data error strobes, a non-PCM detection level, sampling-rate change strobes and the block-start (preamble B) strobe into one flag. After the PLL locks, the flag is held high until a programmable number of block starts has been counted. Only after that is demodulated audio allowed downstream.

A small configuration word arrives as a parallel write strobe from the serial control-bus shifter, which is outside this block. The word selects the post-lock wait length and whether non-PCM data raises the flag. It also decides whether sampling-rate changes count, how short parity-error runs are reported, and whether the flag is forced high. The forced-error setting acts on the flag alone. The mute request follows every other error source and is the only signal the data path uses.

Top module: `rx_err_flag_ctrl`

## Requirements
- R1: After reset, with the PLL unlocked, `err_o` and `mute_o` are both 1. All configuration fields reset to 0. `mute_o` always equals the value the flag would have with the force bit clear.
- R2: After lock, the flag stays high until a number of `blk_start_i` pulses has been counted. That number comes from the wait field in write bits [15:14]: 00 gives 3, 01 gives 24, 10 gives 12 and 11 gives 6. The flag falls in the cycle after the clock edge that samples the last required pulse.
- R3: When `pll_lock_i` is 0, `err_o` and `mute_o` are 1 in that same cycle, and the block-start count is cleared. After relock, the full wait count is needed again.
- R4: Write bit 8 is the non-PCM select. When it is 1, `nonpcm_i`=1 raises both `err_o` and `mute_o`. When it is 0, `nonpcm_i` alone has no effect.
- R5: Write bit 12 is the force bit. When it is 1, `err_o` is 1 and `mute_o` is not affected.
- R6: Write bit 13 is the fs-ignore bit. When it is 0, a qualified fs-change strobe clears the block-start count, so the flag rises after that edge and needs a full wait again. When it is 1, fs-change strobes have no effect.
- R7: While `osc_run_i` is 0, `fs_meas_chg_i` is ignored and only `fs_cs_chg_i` counts as an fs change. While `osc_run_i` is 1, either strobe counts.
- R8: Write bit 9 is the parity mode. A parity error is latched with `sub_stb_i` and held until the next subframe strobe. In mode 0 it raises the flag only while `nonpcm_i` is 1. In mode 1 it raises the flag for that subframe regardless of `nonpcm_i`.
- R9: After 8 consecutive subframes with a parity error, the flag is high in either parity mode. It stays high through further error subframes until a subframe without a parity error is latched. The run counter saturates at 8.
- R10: A data error latched with `sub_stb_i` raises the flag until the next subframe strobe latches a clean subframe.
- R11: The configuration changes only on a cycle with `cfg_we_i`=1. Write bits 11 and 10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write word |
| pll_lock_i | input | 1 | PLL lock status |
| osc_run_i | input | 1 | Oscillator amplifier running |
| blk_start_i | input | 1 | Block-start preamble strobe |
| sub_stb_i | input | 1 | Subframe strobe qualifying the error inputs |
| par_err_i | input | 1 | Parity error for the current subframe |
| dat_err_i | input | 1 | Data error for the current subframe |
| nonpcm_i | input | 1 | Non-PCM data detected |
| fs_meas_chg_i | input | 1 | Measured sampling-rate change strobe |
| fs_cs_chg_i | input | 1 | Channel-status sampling-rate change strobe |
| err_o | output | 1 | Error flag, active high |
| mute_o | output | 1 | Mute request for the audio data path |

## Verification
On every cycle, the assertions check the following:
- Loss of lock forces the flag and the mute request high at once and clears the block-start count.
- The count holds steady when no block start or restart occurs.
- The parity run counter never passes 8 and clears on a clean subframe.
- The force bit always shows on the flag.
- An enabled non-PCM detection always mutes.
- The configuration is stable without a write.

Only the bench's scenarios can show the exact number of block starts each wait code needs and the cycle in which the flag falls. The same holds for how the fs and oscillator qualifiers interact, the mode-dependent treatment of short parity runs, and the eighth-error boundary of the persistent error.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int WORD_W  = 16;
  localparam int CNT_W   = 5;
  localparam int RUN_MAX = 8;

  // write-word bit positions
  localparam int B_WAIT_HI = 15;
  localparam int B_WAIT_LO = 14;
  localparam int B_FS_IGN  = 13;
  localparam int B_FORCE   = 12;
  localparam int B_PARMODE = 9;
  localparam int B_NPCMSEL = 8;

  typedef struct packed {
    logic [1:0] wait_sel;
    logic       fs_ign;
    logic       force_err;
    logic       par_mode;
    logic       src_nonpcm;
  } cfg_t;

  localparam logic [CNT_W-1:0] WAIT_C0 = 5'd3;
  localparam logic [CNT_W-1:0] WAIT_C1 = 5'd24;
  localparam logic [CNT_W-1:0] WAIT_C2 = 5'd12;
  localparam logic [CNT_W-1:0] WAIT_C3 = 5'd6;

  function automatic logic [CNT_W-1:0] wait_target(input logic [1:0] sel);
    unique case (sel)
      2'b00:   return WAIT_C0;
      2'b01:   return WAIT_C1;
      2'b10:   return WAIT_C2;
      default: return WAIT_C3;
    endcase
  endfunction
endpackage

// File: rtl/rx_err_cfg.sv
module rx_err_cfg
  import rx_err_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;
  logic unused_bits;
  assign unused_bits = ^{wdata_i[11:10], wdata_i[7:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.wait_sel   <= wdata_i[B_WAIT_HI:B_WAIT_LO];
      cfg_q.fs_ign     <= wdata_i[B_FS_IGN];
      cfg_q.force_err  <= wdata_i[B_FORCE];
      cfg_q.par_mode   <= wdata_i[B_PARMODE];
      cfg_q.src_nonpcm <= wdata_i[B_NPCMSEL];
    end
  end

  assign cfg_o = cfg_q;

  a_r11_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/rx_err_lock_wait.sv
module rx_err_lock_wait #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             restart_i,
  input  logic             blk_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!lock_i || restart_i) begin
      cnt_q <= '0;
    end else if (blk_i && (cnt_q < target_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q >= target_i);

  a_r3_unlock_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (cnt_q == '0));
  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !restart_i && !blk_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_err_par_run.sv
module rx_err_par_run #(
  parameter int RUN_MAX = 8,
  localparam int RUN_W  = $clog2(RUN_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sub_stb_i,
  input  logic par_err_i,
  input  logic dat_err_i,
  output logic par_q_o,
  output logic dat_q_o,
  output logic persist_o
);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);

  logic [RUN_W-1:0] run_q;
  logic             par_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      par_q <= 1'b0;
      dat_q <= 1'b0;
    end else if (sub_stb_i) begin
      par_q <= par_err_i;
      dat_q <= dat_err_i;
      if (!par_err_i)            run_q <= '0;
      else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
    end
  end

  assign par_q_o   = par_q;
  assign dat_q_o   = dat_q;
  assign persist_o = (run_q == RUN_TOP);

  a_r9_run_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_TOP);
  a_r9_run_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_stb_i && !par_err_i) |=> (run_q == '0));
endmodule

// File: rtl/rx_err_flag_ctrl.sv
module rx_err_flag_ctrl
  import rx_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              pll_lock_i,
  input  logic              osc_run_i,
  input  logic              blk_start_i,
  input  logic              sub_stb_i,
  input  logic              par_err_i,
  input  logic              dat_err_i,
  input  logic              nonpcm_i,
  input  logic              fs_meas_chg_i,
  input  logic              fs_cs_chg_i,
  output logic              err_o,
  output logic              mute_o
);
  cfg_t cfg;
  logic fs_chg, wait_done, par_q, dat_q, persist;
  logic lock_err, data_err, npcm_err, core_err;

  rx_err_cfg #(.DATA_W(WORD_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  // measured fs is only trusted while the oscillator runs
  assign fs_chg = !cfg.fs_ign && (fs_cs_chg_i || (osc_run_i && fs_meas_chg_i));

  rx_err_lock_wait #(.CNT_W(CNT_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (pll_lock_i),
    .restart_i (fs_chg),
    .blk_i     (blk_start_i),
    .target_i  (wait_target(cfg.wait_sel)),
    .done_o    (wait_done)
  );

  rx_err_par_run #(.RUN_MAX(RUN_MAX)) u_par (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sub_stb_i (sub_stb_i),
    .par_err_i (par_err_i),
    .dat_err_i (dat_err_i),
    .par_q_o   (par_q),
    .dat_q_o   (dat_q),
    .persist_o (persist)
  );

  assign lock_err = !pll_lock_i || !wait_done;
  assign data_err = dat_q || persist || (par_q && (cfg.par_mode || nonpcm_i));
  assign npcm_err = cfg.src_nonpcm && nonpcm_i;
  assign core_err = lock_err || data_err || npcm_err;

  assign mute_o = core_err;
  assign err_o  = core_err || cfg.force_err;

  a_r3_unlock_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |-> (err_o && mute_o));
  a_r5_force_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.force_err |-> err_o);
  a_r4_nonpcm_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.src_nonpcm && nonpcm_i) |-> mute_o);
  a_r1_mute_implies_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> err_o);
endmodule

// File: tb/tb_rx_err_flag_ctrl.sv
`timescale 1ns/1ps
module tb_rx_err_flag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wd = '0;
  logic lock = 1'b0, osc = 1'b1, blk = 1'b0, sub = 1'b0, perr = 1'b0, derr = 1'b0;
  logic npcm = 1'b0, fsm = 1'b0, fsc = 1'b0;
  logic err, mute;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_err_flag_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .pll_lock_i(lock), .osc_run_i(osc), .blk_start_i(blk), .sub_stb_i(sub),
    .par_err_i(perr), .dat_err_i(derr), .nonpcm_i(npcm),
    .fs_meas_chg_i(fsm), .fs_cs_chg_i(fsc), .err_o(err), .mute_o(mute)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = w;
    @(negedge clk); cfg_we = 1'b0; cfg_wd = '0;
  endtask

  task automatic pulse_blk();
    @(negedge clk); blk = 1'b1;
    @(negedge clk); blk = 1'b0;
  endtask

  task automatic subframe(input logic p, input logic d);
    @(negedge clk); sub = 1'b1; perr = p; derr = d;
    @(negedge clk); sub = 1'b0; perr = 1'b0; derr = 1'b0;
  endtask

  task automatic relock3();
    @(negedge clk); lock = 1'b0;
    @(negedge clk); lock = 1'b1;
    for (int k = 0; k < 3; k++) pulse_blk();
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset err", err, 1'b1);
    chk("R1 reset mute", mute, 1'b1);
    lock = 1'b1;
    @(negedge clk);
    chk("R1 locked no blocks", err, 1'b1);

    // R2: sweep every wait code
    for (int code = 0; code < 4; code++) begin
      int n;
      n = (code == 0) ? 3 : (code == 1) ? 24 : (code == 2) ? 12 : 6;
      wr(16'(code) << 14);
      @(negedge clk); lock = 1'b0;
      @(negedge clk); lock = 1'b1;
      #1 chk("R2 relocked", err, 1'b1);
      for (int k = 1; k <= n; k++) begin
        pulse_blk();
        chk("R2 wait count", err, (k < n) ? 1'b1 : 1'b0);
        chk("R1 mute tracks", mute, (k < n) ? 1'b1 : 1'b0);
      end
    end

    // R3: unlock mid-run, full wait again
    wr(16'h0000);
    relock3();
    chk("R3 settled", err, 1'b0);
    @(negedge clk); lock = 1'b0;
    #1 chk("R3 same-cycle err", err, 1'b1);
    chk("R3 same-cycle mute", mute, 1'b1);
    pulse_blk();
    @(negedge clk); lock = 1'b1;
    pulse_blk(); pulse_blk();
    chk("R3 two blocks not enough", err, 1'b1);
    pulse_blk();
    chk("R3 third block clears", err, 1'b0);

    // R4 non-PCM select
    @(negedge clk); npcm = 1'b1;
    #1 chk("R4 nonpcm ignored", err, 1'b0);
    wr(16'h0100);
    chk("R4 nonpcm err", err, 1'b1);
    chk("R4 nonpcm mute", mute, 1'b1);
    @(negedge clk); npcm = 1'b0;
    #1 chk("R4 nonpcm gone", err, 1'b0);

    // R5 force
    wr(16'h1000);
    chk("R5 force err", err, 1'b1);
    chk("R5 force no mute", mute, 1'b0);
    wr(16'h0000);
    chk("R5 force released", err, 1'b0);

    // R6 fs change
    @(negedge clk); fsc = 1'b1;
    @(negedge clk); fsc = 1'b0;
    chk("R6 fs change raises", err, 1'b1);
    for (int k = 1; k <= 3; k++) begin
      pulse_blk();
      chk("R6 rewait", err, (k < 3) ? 1'b1 : 1'b0);
    end
    wr(16'h2000);
    @(negedge clk); fsc = 1'b1; fsm = 1'b1;
    @(negedge clk); fsc = 1'b0; fsm = 1'b0;
    chk("R6 fs ignored", err, 1'b0);
    wr(16'h0000);

    // R7 oscillator qualifier
    @(negedge clk); osc = 1'b0; fsm = 1'b1;
    @(negedge clk); fsm = 1'b0;
    chk("R7 meas ignored osc off", err, 1'b0);
    @(negedge clk); fsc = 1'b1;
    @(negedge clk); fsc = 1'b0;
    chk("R7 cs counts osc off", err, 1'b1);
    osc = 1'b1;
    for (int k = 0; k < 3; k++) pulse_blk();
    @(negedge clk); fsm = 1'b1;
    @(negedge clk); fsm = 1'b0;
    chk("R7 meas counts osc on", err, 1'b1);
    for (int k = 0; k < 3; k++) pulse_blk();
    chk("R7 recovered", err, 1'b0);

    // R8 parity mode
    subframe(1'b1, 1'b0);
    chk("R8 mode0 no nonpcm", err, 1'b0);
    @(negedge clk); npcm = 1'b1;
    #1 chk("R8 mode0 with nonpcm", err, 1'b1);
    @(negedge clk); npcm = 1'b0;
    subframe(1'b0, 1'b0);
    wr(16'h0200);
    subframe(1'b1, 1'b0);
    chk("R8 mode1 flagged", err, 1'b1);
    subframe(1'b0, 1'b0);
    chk("R8 mode1 clean", err, 1'b0);
    wr(16'h0000);

    // R9 persistent parity run
    for (int k = 1; k <= 9; k++) begin
      subframe(1'b1, 1'b0);
      chk("R9 run boundary", err, (k >= 8) ? 1'b1 : 1'b0);
    end
    subframe(1'b0, 1'b0);
    chk("R9 clean clears", err, 1'b0);

    // R10 data error
    subframe(1'b0, 1'b1);
    chk("R10 data err", err, 1'b1);
    chk("R10 data mute", mute, 1'b1);
    subframe(1'b0, 1'b0);
    chk("R10 data clean", err, 1'b0);

    // R11 reserved bits and write gating
    wr(16'h0C00);
    chk("R11 reserved no effect", err, 1'b0);
    @(negedge clk); cfg_wd = 16'h1000;
    @(negedge clk); cfg_wd = '0;
    chk("R11 no write no change", err, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule